// File: doc/BRIEF.md
# TDM Bus Clock and Frame Generator

This block produces the timing set of a time-division-multiplexed backplane: a double-rate bit clock, a single-rate bit clock at half that rate, and an active-low 8 kHz frame pulse. Three rate profiles are selectable. The double-rate clock runs at 16.384, 8.192 or 4.096 MHz, and the single-rate clock at 8.192, 4.096 or 2.048 MHz. All three signals come from one phase counter. The block is clocked at twice the 16.384 MHz timing rate (32.768 MHz), so one `clk` cycle is one half-period of the fastest bus clock. One frame is 2048 periods of the 16.384 MHz rate, which is 4096 `clk` cycles. At the frame boundary, every generated clock has a rising edge.

A role state machine has three states: `ST_MASTER`, `ST_SLAVE` and `ST_ALT` (master-alternate). Each cycle it takes one of the transitions TO_MASTER, TO_SLAVE or TO_ALT, as the `mode_i` code selects. In `ST_MASTER` the three bus drivers are enabled. In the other two states the drivers are off and the bus lines are taken in as inputs. The slave-side single-rate clock can come from its own pin or from the incoming double-rate clock divided by two. A standby 8 kHz frame counter runs while the block is not master, so it is ready to take over the bus. A secondary 8 kHz output carries the master frame in `ST_MASTER` and the standby frame otherwise, and its driver is enabled by a control bit.

Top module: `tdm_bus_timing_gen`

## Requirements
- R1: While `rst_n` is low: all four output enables are 0, `x2_o`=1, `x1_o`=1, `fs_n_o`=0, `stby_fs_n_o`=1, `x1_slave_o`=0 and `fs_slave_n_o`=1. The role is `ST_SLAVE`.
- R2: Let the active rate code be t. A code of 0, 1 or 2 on `bus_type_i` selects t equal to that code. `x2_o` then has a period of 2^(t+1) `clk` cycles and `x1_o` has a period of 2^(t+2) cycles. Counting n as the cycles since reset (mod 4096), `x2_o` = NOT bit t of n and `x1_o` = NOT bit t+1 of n.
- R3: A frame is 4096 `clk` cycles. `fs_n_o` is low for 2^t cycles before the boundary and 2^t cycles after it, which is one double-rate period. In the first cycle of a frame, `x2_o`, `x1_o` and the low frame pulse coincide.
- R4: The bus type is sampled only at a frame boundary and holds for the whole frame. Code 3 acts as code 2.
- R5: `mode_i` codes are 0 = master, 2 = master-alternate, and 1 or 3 = slave. The role changes one cycle after the code is applied. `x2_oe_o`, `x1_oe_o` and `fs_oe_o` are 1 only in the master role.
- R6: In slave use, the bus inputs pass through a two-stage synchronizer, so `fs_slave_n_o` follows `fs_bus_n_i` two cycles later. With `x1_div_sel_i`=0, `x1_slave_o` follows `x1_bus_i` the same way. With `x1_div_sel_i`=1, `x1_slave_o` toggles once per rising edge of `x2_bus_i`.
- R7: Outside the master role, a standby counter steps through a 4096-step frame. `stby_fs_n_o` is low for 2 steps before and 2 steps after its boundary. In the master role the counter is cleared and `stby_fs_n_o` stays 1.
- R8: With `stby_alt_sel_i`=0 the standby counter steps every cycle. With `stby_alt_sel_i`=1 it steps only in cycles where `stby_alt_tick_i` is 1.
- R9: `sec8k_oe_o` equals `sec_en_i` delayed by one cycle. `sec8k_o` carries `fs_n_o` in the master role and `stby_fs_n_o` otherwise.
- R10: The master phase counter runs in every role, so the bus timing of R2 and R3 is unbroken across role changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 MHz clock, twice the timing rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Role code (0 master, 1/3 slave, 2 master-alternate) |
| bus_type_i | input | 2 | Rate profile code, taken at frame boundary |
| x1_div_sel_i | input | 1 | Slave single-rate source: 0 pin, 1 double-rate/2 |
| stby_alt_sel_i | input | 1 | Standby counter step source: 0 every cycle, 1 tick input |
| stby_alt_tick_i | input | 1 | Step enable for the standby counter |
| sec_en_i | input | 1 | Enable for the secondary 8 kHz driver |
| x2_bus_i | input | 1 | Double-rate clock from the bus |
| x1_bus_i | input | 1 | Single-rate clock from the bus |
| fs_bus_n_i | input | 1 | Frame pulse from the bus, active low |
| x2_o | output | 1 | Generated double-rate clock |
| x1_o | output | 1 | Generated single-rate clock |
| fs_n_o | output | 1 | Generated frame pulse, active low |
| x2_oe_o | output | 1 | Driver enable for the double-rate clock |
| x1_oe_o | output | 1 | Driver enable for the single-rate clock |
| fs_oe_o | output | 1 | Driver enable for the frame pulse |
| x1_slave_o | output | 1 | Slave-side single-rate clock |
| fs_slave_n_o | output | 1 | Synchronized bus frame pulse |
| stby_fs_n_o | output | 1 | Standby frame pulse, active low |
| sec8k_o | output | 1 | Secondary 8 kHz signal |
| sec8k_oe_o | output | 1 | Driver enable for the secondary output |

## Verification
The generated bus timing is first run in fixed profiles across several frame boundaries. After that, the profile code is changed in mid-frame, including code 3. This shows whether a new profile is applied at once or only at the boundary, and whether the frame pulse stays centred on the boundary. Random segments then mix role codes, profile codes, the secondary enable and an irregular standby tick. These segments separate a standby counter that steps on the wrong condition or fails to clear in the master role, and a secondary mux that picks the wrong frame. Directed pin patterns on the bus inputs check the synchronizer latency and the divide-by-two parity, which tells pin selection apart from divider selection.

// File: rtl/tdm_timing_pkg.sv
package tdm_timing_pkg;

    typedef enum logic [1:0] {
        ST_SLAVE  = 2'd0,
        ST_MASTER = 2'd1,
        ST_ALT    = 2'd2
    } bus_role_e;

    localparam logic [1:0] MODE_MASTER = 2'd0;
    localparam logic [1:0] MODE_SLAVE  = 2'd1;
    localparam logic [1:0] MODE_ALT    = 2'd2;

endpackage

// File: rtl/tdm_phase_gen.sv
module tdm_phase_gen #(
    parameter int FRAME_CYC = 4096,
    parameter int NUM_RATES = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(NUM_RATES)-1:0] bus_type_i,
    output logic                         x2_o,
    output logic                         x1_o,
    output logic                         fs_n_o
);
    localparam int PW = $clog2(FRAME_CYC);
    localparam int TW = $clog2(NUM_RATES);
    localparam logic [TW-1:0] TOP_CODE = TW'(NUM_RATES - 1);

    logic [PW-1:0]        ph_q, ph_nxt;
    logic [TW-1:0]        typ_q, typ_nxt, typ_code;
    logic [NUM_RATES-1:0] x2_tap, x1_tap, fs_tap;

    always_comb begin
        typ_code = (bus_type_i > TOP_CODE) ? TOP_CODE : bus_type_i;
        ph_nxt   = (ph_q == PW'(FRAME_CYC - 1)) ? '0 : ph_q + 1'b1;
        typ_nxt  = (ph_nxt == '0) ? typ_code : typ_q;
    end

    for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
        localparam int HALF = 1 << r;
        assign x2_tap[r] = ~ph_nxt[r];
        assign x1_tap[r] = ~ph_nxt[r+1];
        assign fs_tap[r] = ~((ph_nxt < PW'(HALF)) ||
                             (ph_nxt >= PW'(FRAME_CYC - HALF)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= '0;
            typ_q  <= '0;
            x2_o   <= 1'b1;
            x1_o   <= 1'b1;
            fs_n_o <= 1'b0;
        end else begin
            ph_q   <= ph_nxt;
            typ_q  <= typ_nxt;
            x2_o   <= x2_tap[typ_nxt];
            x1_o   <= x1_tap[typ_nxt];
            fs_n_o <= fs_tap[typ_nxt];
        end
    end

    AST_BOUNDARY_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == '0) |-> (x2_o && x1_o && !fs_n_o)); // R3
    AST_TYPE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q != '0) |-> $stable(typ_q)); // R4
    AST_FS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_n_o) |-> !x2_o); // R3

endmodule

// File: rtl/tdm_standby_frame.sv
module tdm_standby_frame #(
    parameter int FRAME_CYC = 4096,
    parameter int EDGE_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic use_alt_i,
    input  logic alt_tick_i,
    output logic fs_n_o
);
    localparam int PW = $clog2(FRAME_CYC);

    logic [PW-1:0] sb_q, sb_nxt;
    logic          step;

    always_comb begin
        step = !use_alt_i || alt_tick_i;
        if (hold_i)
            sb_nxt = '0;
        else if (step)
            sb_nxt = (sb_q == PW'(FRAME_CYC - 1)) ? '0 : sb_q + 1'b1;
        else
            sb_nxt = sb_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sb_q   <= '0;
            fs_n_o <= 1'b1;
        end else begin
            sb_q   <= sb_nxt;
            fs_n_o <= hold_i ? 1'b1 :
                      ~((sb_nxt < PW'(EDGE_CYC)) ||
                        (sb_nxt >= PW'(FRAME_CYC - EDGE_CYC)));
        end
    end

    AST_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> fs_n_o); // R7
    AST_STBY_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && use_alt_i && !alt_tick_i) |=> $stable(sb_q)); // R8

endmodule

// File: rtl/tdm_slave_in.sv
module tdm_slave_in #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic x2_bus_i,
    input  logic x1_bus_i,
    input  logic fs_bus_n_i,
    input  logic div_sel_i,
    output logic x1_o,
    output logic fs_n_o
);
    localparam logic [2:0] SYNC_RST = 3'b100;

    logic [2:0] sync_q [SYNC_STAGES];
    logic [2:0] sync_out;
    logic       x2_last_q, div_q, x2_rise;

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sync_q[s] <= SYNC_RST;
            else if (s == 0)
                sync_q[s] <= {fs_bus_n_i, x1_bus_i, x2_bus_i};
            else
                sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
        end
    end

    assign sync_out = sync_q[SYNC_STAGES-1];
    assign x2_rise  = sync_out[0] && !x2_last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x2_last_q <= 1'b0;
            div_q     <= 1'b0;
        end else begin
            x2_last_q <= sync_out[0];
            div_q     <= div_q ^ x2_rise;
        end
    end

    assign x1_o   = div_sel_i ? div_q : sync_out[1];
    assign fs_n_o = sync_out[2];

    AST_DIV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(sync_out[0]) |=> $stable(div_q)); // R6

endmodule

// File: rtl/tdm_bus_timing_gen.sv
module tdm_bus_timing_gen
    import tdm_timing_pkg::*;
#(
    parameter int FRAME_CYC   = 4096,
    parameter int NUM_RATES   = 3,
    parameter int STBY_EDGE   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic [1:0] bus_type_i,
    input  logic       x1_div_sel_i,
    input  logic       stby_alt_sel_i,
    input  logic       stby_alt_tick_i,
    input  logic       sec_en_i,
    input  logic       x2_bus_i,
    input  logic       x1_bus_i,
    input  logic       fs_bus_n_i,
    output logic       x2_o,
    output logic       x1_o,
    output logic       fs_n_o,
    output logic       x2_oe_o,
    output logic       x1_oe_o,
    output logic       fs_oe_o,
    output logic       x1_slave_o,
    output logic       fs_slave_n_o,
    output logic       stby_fs_n_o,
    output logic       sec8k_o,
    output logic       sec8k_oe_o
);
    bus_role_e st_q, st_d;
    logic      drv_on, stby_hold, sec_from_master, sec_oe_q;

    // Role transitions: TO_MASTER, TO_ALT, TO_SLAVE
    always_comb begin
        unique case (mode_i)
            MODE_MASTER: st_d = ST_MASTER;
            MODE_ALT:    st_d = ST_ALT;
            default:     st_d = ST_SLAVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_SLAVE;
            sec_oe_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            sec_oe_q <= sec_en_i;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_MASTER: begin
                drv_on          = 1'b1;
                stby_hold       = 1'b1;
                sec_from_master = 1'b1;
            end
            ST_ALT: begin
                drv_on          = 1'b0;
                stby_hold       = 1'b0;
                sec_from_master = 1'b0;
            end
            default: begin
                drv_on          = 1'b0;
                stby_hold       = 1'b0;
                sec_from_master = 1'b0;
            end
        endcase
    end

    tdm_phase_gen #(.FRAME_CYC(FRAME_CYC), .NUM_RATES(NUM_RATES)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_type_i ($clog2(NUM_RATES)'(bus_type_i)),
        .x2_o       (x2_o),
        .x1_o       (x1_o),
        .fs_n_o     (fs_n_o)
    );

    tdm_standby_frame #(.FRAME_CYC(FRAME_CYC), .EDGE_CYC(STBY_EDGE)) u_stby (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_i     (stby_hold),
        .use_alt_i  (stby_alt_sel_i),
        .alt_tick_i (stby_alt_tick_i),
        .fs_n_o     (stby_fs_n_o)
    );

    tdm_slave_in #(.SYNC_STAGES(SYNC_STAGES)) u_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .x2_bus_i   (x2_bus_i),
        .x1_bus_i   (x1_bus_i),
        .fs_bus_n_i (fs_bus_n_i),
        .div_sel_i  (x1_div_sel_i),
        .x1_o       (x1_slave_o),
        .fs_n_o     (fs_slave_n_o)
    );

    assign x2_oe_o    = drv_on;
    assign x1_oe_o    = drv_on;
    assign fs_oe_o    = drv_on;
    assign sec8k_oe_o = sec_oe_q;
    assign sec8k_o    = sec_from_master ? fs_n_o : stby_fs_n_o;

    AST_OE_FROM_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(x2_oe_o) |-> ($past(mode_i) == MODE_MASTER)); // R5
    AST_SEC_OE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec8k_oe_o) |-> $past(sec_en_i)); // R9

endmodule

// File: tb/tdm_bus_timing_gen_tb.sv
`timescale 1ns/1ps
module tdm_bus_timing_gen_tb;
    localparam int F = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'd1, bus_type = 2'd0;
    logic div_sel = 0, stby_sel = 0, alt_tick = 0, sec_en = 0;
    logic x2_bus = 0, x1_bus = 0, fs_bus_n = 1;
    logic x2, x1, fs_n, x2_oe, x1_oe, fs_oe, x1_sl, fs_sl_n, stby_n, sec, sec_oe;

    int n_chk = 0, n_fail = 0;
    bit cmp_en = 0, done = 0;
    int mph, mtyp, mrole, msb;
    logic mstby, msec;

    always #2.5 clk = ~clk;

    tdm_bus_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .bus_type_i(bus_type),
        .x1_div_sel_i(div_sel), .stby_alt_sel_i(stby_sel), .stby_alt_tick_i(alt_tick),
        .sec_en_i(sec_en), .x2_bus_i(x2_bus), .x1_bus_i(x1_bus), .fs_bus_n_i(fs_bus_n),
        .x2_o(x2), .x1_o(x1), .fs_n_o(fs_n), .x2_oe_o(x2_oe), .x1_oe_o(x1_oe),
        .fs_oe_o(fs_oe), .x1_slave_o(x1_sl), .fs_slave_n_o(fs_sl_n),
        .stby_fs_n_o(stby_n), .sec8k_o(sec), .sec8k_oe_o(sec_oe)
    );

    function automatic logic [2:0] exp_bus(int ph, int t);
        int half = 1 << t;
        exp_bus[2] = !((ph >> t) & 1);
        exp_bus[1] = !((ph >> (t + 1)) & 1);
        exp_bus[0] = !(ph < half || ph >= F - half);
    endfunction

    function automatic logic exp_stby(int sb);
        return !(sb < 2 || sb >= F - 2);
    endfunction

    function automatic int map_type(logic [1:0] c);
        return (c == 2'd3) ? 2 : int'(c);
    endfunction

    function automatic int role_of(logic [1:0] m);   // 0 master, 1 slave, 2 alt
        return (m == 2'd0) ? 0 : (m == 2'd2) ? 2 : 1;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference model, inputs are stable at posedge (driven at negedge)
    always @(posedge clk) begin
        if (!rst_n) begin
            mph = 0; mtyp = 0; mrole = 1; msb = 0; mstby = 1; msec = 0;
        end else begin
            mph = (mph + 1) % F;
            if (mph == 0) mtyp = map_type(bus_type);
            if (mrole == 0) begin
                msb = 0; mstby = 1;
            end else begin
                if (!stby_sel || alt_tick) msb = (msb + 1) % F;
                mstby = exp_stby(msb);
            end
            mrole = role_of(mode);
            msec  = sec_en;
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            check("R2 R3 R4 R10 bus timing", {5'd0, x2, x1, fs_n}, {5'd0, exp_bus(mph, mtyp)});
            check("R5 driver enables", {5'd0, x2_oe, x1_oe, fs_oe}, {5'd0, {3{mrole == 0}}});
            check("R7 R8 standby frame", {7'd0, stby_n}, {7'd0, mstby});
            check("R9 secondary out", {6'd0, sec_oe, sec},
                  {6'd0, msec, (mrole == 0) ? exp_bus(mph, mtyp)[0] : mstby});
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rand_seg(int len);
        @(negedge clk);
        mode     = 2'($urandom % 4);
        bus_type = 2'($urandom % 4);
        sec_en   = 1'($urandom % 2);
        stby_sel = 1'($urandom % 2);
        repeat (len) begin
            @(negedge clk);
            alt_tick = 1'($urandom % 2);
        end
    endtask

    initial begin
        int rises;
        void'($urandom(32'h1d5e_77a3));
        cycles(4);
        #1;
        check("R1 reset enables", {4'd0, x2_oe, x1_oe, fs_oe, sec_oe}, 8'h00);
        check("R1 reset bus levels", {5'd0, x2, x1, fs_n}, 8'h06);
        check("R1 reset standby/slave", {5'd0, stby_n, x1_sl, fs_sl_n}, 8'h05);
        @(negedge clk);
        rst_n  = 1'b1;
        cmp_en = 1'b1;
        // directed: fixed profiles over boundaries, then mid-frame changes
        mode = 2'd0; bus_type = 2'd0; sec_en = 1;
        cycles(5000);
        bus_type = 2'd1; cycles(4200);
        bus_type = 2'd3; cycles(3000);
        bus_type = 2'd0; cycles(1500);
        mode = 2'd2; stby_sel = 1; cycles(6000);
        mode = 2'd1; stby_sel = 0; bus_type = 2'd2; cycles(5000);
        for (int i = 0; i < 25; i++) rand_seg(100 + int'($urandom % 3000));
        // R6 pin path and divider
        div_sel = 0; x1_bus = 1; fs_bus_n = 0;
        cycles(3); #1;
        check("R6 x1 pin sync high", {7'd0, x1_sl}, 8'd1);
        check("R6 fs sync low", {7'd0, fs_sl_n}, 8'd0);
        x1_bus = 0; fs_bus_n = 1;
        cycles(1); #1;
        check("R6 x1 latency not early", {7'd0, x1_sl}, 8'd1);
        cycles(2); #1;
        check("R6 x1 pin sync low", {7'd0, x1_sl}, 8'd0);
        check("R6 fs sync high", {7'd0, fs_sl_n}, 8'd1);
        div_sel = 1; rises = 0;
        for (int k = 0; k < 10; k++) begin
            x2_bus = ~x2_bus; if (x2_bus) rises++;
            cycles(3);
        end
        cycles(6); #1;
        check("R6 divider parity a", {7'd0, x1_sl}, {7'd0, 1'(rises % 2)});
        for (int k = 0; k < 6; k++) begin
            x2_bus = ~x2_bus; if (x2_bus) rises++;
            cycles(4);
        end
        cycles(6); #1;
        check("R6 divider parity b", {7'd0, x1_sl}, {7'd0, 1'(rises % 2)});
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule